// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is a clocked controller for a 12-bit analog-to-digital converter. The converter shares the controller's clock. It returns each result over an 8-bit data bus in two halves. The controller sends it commands with three active-low strobes: write (`wr_n_o`), read (`rd_n_o`) and control/data (`cd_n_o`). Each operation uses its own combination of the three. The converter's chip select is wired permanently active, so the controller has no chip-select pin. The strobes come straight from flip-flops, so they only change on a clock edge.

After reset the controller sends one mode-programming cycle. In that cycle it drives the bus and puts code `000` on the three lowest lines, which selects unipolar straight-binary 12-bit output. After that, each start request causes the following steps:
1. A one-cycle conversion strobe.
2. A fixed wait counted on the shared clock. The converter's busy state is never polled.
3. A read of the high nibble.
4. One idle cycle.
5. A read of the low byte.

The 12 bits are then combined with the overrange input into a 14-bit output word, and a one-cycle `done_o` pulse marks the update.

The state machine has these states:
- `ST_BOOT` is the reset state. It goes to `ST_MODE`.
- `ST_MODE` is the programming cycle. It goes to `ST_MGAP`.
- `ST_MGAP` is an idle gap. It goes to `ST_IDLE`.
- `ST_IDLE` goes to `ST_CONV` when a start request or a held start is present, and otherwise stays in `ST_IDLE`.
- `ST_CONV` is the conversion strobe. It goes to `ST_WAIT`.
- `ST_WAIT` lasts `WAIT_CYC` cycles. It then goes to `ST_RDHI`.
- `ST_RDHI` is the high-nibble read. It goes to `ST_RGAP`.
- `ST_RGAP` is an idle gap. It goes to `ST_RDLO`.
- `ST_RDLO` is the low-byte read. It goes back to `ST_IDLE`.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While `rst_n` is low, `wr_n_o`, `rd_n_o` and `cd_n_o` are high, and `bus_oe_o`, `done_o` and `result_o` are all 0.
- R2: In the first cycle after reset is released there is exactly one programming cycle, and it never recurs until the next reset. In that cycle `wr_n_o`=0, `rd_n_o`=1, `cd_n_o`=1, `bus_oe_o`=1 and `bus_o[2:0]`=3'b000.
- R3: If `start_i` is sampled high at a clock edge while the controller is idle, then in the cycle after that edge `cd_n_o`=0, `wr_n_o`=0 and `rd_n_o`=1 for exactly one cycle.
- R4: After the conversion strobe, exactly `WAIT_CYC` cycles (13 by default) pass with all three strobes high before the first read strobe.
- R5: The first read is one cycle with `cd_n_o`=1, `wr_n_o`=1 and `rd_n_o`=0. `bus_i[3:0]` is taken at the end of that cycle as result bits [11:8]. `bus_i[7:4]` is ignored.
- R6: After one cycle with all strobes high, the second read follows. It is one cycle with `cd_n_o`=0, `rd_n_o`=0 and `wr_n_o`=1. `bus_i[7:0]` is taken at its end as result bits [7:0].
- R7: `result_o` is loaded at the clock edge that ends the second read, and it is stable at all other times. Its bits [11:0] hold the result, bit 12 is 0, and bit 13 is the inverse of `ovd_n_i` sampled at that edge, so 1 means overrange. `done_o` is 1 for exactly that one cycle.
- R8: A start request sampled in any state from the conversion strobe through the second read is ignored. No further conversion strobe follows it.
- R9: A start request sampled while the controller is still booting (from reset release until the programming gap ends) is held. The conversion strobe then appears in the fourth cycle after reset release.
- R10: No strobe stays low for more than one cycle, and read and write are never low together. `bus_oe_o` is 1 only during the programming cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the converter |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Conversion request, sampled on clock edges |
| ovd_n_i | input | 1 | Active-low common-mode overrange flag |
| bus_i | input | 8 | Data returned by the converter |
| bus_o | output | 8 | Mode code driven toward the converter |
| bus_oe_o | output | 1 | Bus drive enable |
| wr_n_o | output | 1 | Registered active-low write strobe |
| rd_n_o | output | 1 | Registered active-low read strobe |
| cd_n_o | output | 1 | Registered control (1) / data (0) select |
| result_o | output | 14 | Output word: overrange flag, zero bit, 12-bit result |
| done_o | output | 1 | One-cycle pulse when `result_o` is loaded |

## Verification
Take edge k as the edge that samples a start request in the idle state. Then:
- The conversion strobe is visible after edge k.
- The first read is visible after edge k+1+`WAIT_CYC`.
- The second read is visible two cycles after the first read.
- `result_o` and `done_o` change at the edge that ends the second read.

The bench moves through this timeline one falling edge at a time and checks the strobe pattern of every cycle. This includes each wait cycle, so a wait that is one cycle too short or too long is caught at the exact cycle. The converter model drives the bus from the registered strobes, and the bench compares the result on the first falling edge after the capturing edge.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [3:0] {
        ST_BOOT,
        ST_MODE,
        ST_MGAP,
        ST_IDLE,
        ST_CONV,
        ST_WAIT,
        ST_RDHI,
        ST_RGAP,
        ST_RDLO
    } seq_state_e;

    typedef struct packed {
        logic wr_n;
        logic rd_n;
        logic cd_n;
        logic oe;
    } strobe_t;

    // Strobe levels wanted while the sequencer sits in a given state.
    function automatic strobe_t strobe_for(seq_state_e s);
        strobe_t v;
        v.wr_n = 1'b1;
        v.rd_n = 1'b1;
        v.cd_n = 1'b1;
        v.oe   = 1'b0;
        unique case (s)
            ST_MODE: begin
                v.wr_n = 1'b0;
                v.oe   = 1'b1;
            end
            ST_CONV: begin
                v.wr_n = 1'b0;
                v.cd_n = 1'b0;
            end
            ST_RDHI: begin
                v.rd_n = 1'b0;
            end
            ST_RDLO: begin
                v.rd_n = 1'b0;
                v.cd_n = 1'b0;
            end
            default: begin
                v.wr_n = 1'b1;
            end
        endcase
        return v;
    endfunction

endpackage

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int WAIT_CYC = 13
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    output seq_state_e nxt_o,
    output logic       cap_hi_o,
    output logic       cap_lo_o
);

    localparam int CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;

    seq_state_e       state;
    seq_state_e       nxt;
    logic             pend;
    logic [CNT_W-1:0] cnt;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_BOOT;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_BOOT: nxt = ST_MODE;
            ST_MODE: nxt = ST_MGAP;
            ST_MGAP: nxt = ST_IDLE;
            ST_IDLE: nxt = (start_i || pend) ? ST_CONV : ST_IDLE;
            ST_CONV: nxt = ST_WAIT;
            ST_WAIT: nxt = (cnt == '0) ? ST_RDHI : ST_WAIT;
            ST_RDHI: nxt = ST_RGAP;
            ST_RGAP: nxt = ST_RDLO;
            ST_RDLO: nxt = ST_IDLE;
            default: nxt = ST_BOOT;
        endcase
    end

    // Start held while booting
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (state == ST_IDLE)
            pend <= 1'b0;
        else if (start_i && (state inside {ST_BOOT, ST_MODE, ST_MGAP}))
            pend <= 1'b1;
    end

    // Wait-down counter, loaded in the conversion cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (state == ST_CONV)
            cnt <= CNT_W'(WAIT_CYC - 1);
        else if ((state == ST_WAIT) && (cnt != '0))
            cnt <= cnt - 1'b1;
    end

    // Outputs
    always_comb begin
        nxt_o    = nxt;
        cap_hi_o = (state == ST_RDHI);
        cap_lo_o = (state == ST_RDLO);
    end

    // Independent up-counter measuring the time spent waiting
    logic [CNT_W:0] wchk;
    always_ff @(posedge clk) begin
        if (!rst_n)                wchk <= '0;
        else if (state == ST_WAIT) wchk <= wchk + 1'b1;
        else                       wchk <= '0;
    end

    AST_WAIT_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RDHI) |-> (wchk == (CNT_W+1)'(WAIT_CYC))); // R4

    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {ST_CONV, ST_WAIT, ST_RDHI, ST_RGAP, ST_RDLO}) |=> (state != ST_CONV)); // R8

    AST_PEND_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend) |-> (state == ST_CONV)); // R9

    AST_MODE_AFTER_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MODE) |-> ($past(state) == ST_BOOT)); // R2

endmodule

// File: rtl/adc_strobe_drv.sv
module adc_strobe_drv
    import adc_seq_pkg::*;
#(
    parameter int             BUS_W     = 8,
    parameter int             MODE_W    = 3,
    parameter logic [MODE_W-1:0] MODE_CODE = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  seq_state_e       nxt_i,
    output logic             wr_n_o,
    output logic             rd_n_o,
    output logic             cd_n_o,
    output logic             bus_oe_o,
    output logic [BUS_W-1:0] bus_o
);

    strobe_t stb_q;

    // Strobes are flops loaded from the decoded next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q.wr_n <= 1'b1;
            stb_q.rd_n <= 1'b1;
            stb_q.cd_n <= 1'b1;
            stb_q.oe   <= 1'b0;
        end else begin
            stb_q <= strobe_for(nxt_i);
        end
    end

    always_comb begin
        wr_n_o   = stb_q.wr_n;
        rd_n_o   = stb_q.rd_n;
        cd_n_o   = stb_q.cd_n;
        bus_oe_o = stb_q.oe;
    end

    // Mode code on the low lines, zero above.
    for (genvar gi = 0; gi < BUS_W; gi++) begin : g_bus
        if (gi < MODE_W) begin : g_code
            assign bus_o[gi] = MODE_CODE[gi];
        end else begin : g_zero
            assign bus_o[gi] = 1'b0;
        end
    end

    AST_BUS_ONLY_IN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe_o |-> (!wr_n_o && rd_n_o && cd_n_o)); // R10

    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n_o |=> wr_n_o); // R10

    AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |=> rd_n_o); // R10

    AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n_o && !wr_n_o)); // R10

endmodule

// File: rtl/adc_result_asm.sv
module adc_result_asm #(
    parameter int BUS_W = 8,
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_hi_i,
    input  logic             cap_lo_i,
    input  logic [BUS_W-1:0] bus_i,
    input  logic             ovd_n_i,
    output logic [RES_W+1:0] result_o,
    output logic             done_o
);

    localparam int HI_W = RES_W - BUS_W;

    logic [HI_W-1:0] hi_q;

    always_ff @(posedge clk) begin
        if (!rst_n)        hi_q <= '0;
        else if (cap_hi_i) hi_q <= bus_i[HI_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            done_o   <= 1'b0;
        end else begin
            done_o <= cap_lo_i;
            if (cap_lo_i)
                result_o <= {~ovd_n_i, 1'b0, hi_q, bus_i};
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7

    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o)); // R7

    AST_HI_BEFORE_LO: assert property (@(posedge clk) disable iff (!rst_n)
        cap_lo_i |-> $past(cap_hi_i, 2)); // R6

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int             BUS_W     = 8,
    parameter int             RES_W     = 12,
    parameter int             WAIT_CYC  = 13,
    parameter logic [2:0]     MODE_CODE = 3'b000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             ovd_n_i,
    input  logic [BUS_W-1:0] bus_i,
    output logic [BUS_W-1:0] bus_o,
    output logic             bus_oe_o,
    output logic             wr_n_o,
    output logic             rd_n_o,
    output logic             cd_n_o,
    output logic [RES_W+1:0] result_o,
    output logic             done_o
);

    seq_state_e nxt;
    logic       cap_hi;
    logic       cap_lo;

    adc_seq_fsm #(
        .WAIT_CYC (WAIT_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .nxt_o    (nxt),
        .cap_hi_o (cap_hi),
        .cap_lo_o (cap_lo)
    );

    adc_strobe_drv #(
        .BUS_W     (BUS_W),
        .MODE_W    (3),
        .MODE_CODE (MODE_CODE)
    ) u_stb (
        .clk      (clk),
        .rst_n    (rst_n),
        .nxt_i    (nxt),
        .wr_n_o   (wr_n_o),
        .rd_n_o   (rd_n_o),
        .cd_n_o   (cd_n_o),
        .bus_oe_o (bus_oe_o),
        .bus_o    (bus_o)
    );

    adc_result_asm #(
        .BUS_W (BUS_W),
        .RES_W (RES_W)
    ) u_res (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_hi_i (cap_hi),
        .cap_lo_i (cap_lo),
        .bus_i    (bus_i),
        .ovd_n_i  (ovd_n_i),
        .result_o (result_o),
        .done_o   (done_o)
    );

endmodule

// File: tb/tb_adc_seq_ctrl.sv
`timescale 1ns/1ps
module tb_adc_seq_ctrl;

    localparam int WAIT = 13;
    localparam logic [2:0] P_MODE = 3'b011; // {wr_n, rd_n, cd_n}
    localparam logic [2:0] P_CONV = 3'b010;
    localparam logic [2:0] P_RDHI = 3'b101;
    localparam logic [2:0] P_RDLO = 3'b100;
    localparam logic [2:0] P_IDLE = 3'b111;

    // {hi bus byte, lo bus byte, ovd_n, expected result}
    localparam int NV = 6;
    localparam logic [30:0] VEC [NV] = '{
        {8'hF3, 8'h5A, 1'b1, 14'h035A},
        {8'h0F, 8'hFF, 1'b1, 14'h0FFF},
        {8'hA0, 8'h00, 1'b0, 14'h2000},
        {8'h08, 8'h01, 1'b0, 14'h2801},
        {8'h5C, 8'h3C, 1'b1, 14'h0C3C},
        {8'hFF, 8'h80, 1'b0, 14'h2F80}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic        ovd_n;
    logic [7:0]  bus_i;
    logic [7:0]  bus_o;
    logic        bus_oe;
    logic        wr_n, rd_n, cd_n;
    logic [13:0] result;
    logic        done;
    logic [7:0]  cur_hi, cur_lo;

    int checks = 0;
    int errs   = 0;
    int modecnt = 0;
    int busviol = 0;

    always #4 clk = ~clk;

    adc_seq_ctrl #(.WAIT_CYC(WAIT)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .ovd_n_i(ovd_n),
        .bus_i(bus_i), .bus_o(bus_o), .bus_oe_o(bus_oe),
        .wr_n_o(wr_n), .rd_n_o(rd_n), .cd_n_o(cd_n),
        .result_o(result), .done_o(done)
    );

    // Converter model: answers the two read strobes
    always_comb begin
        if (!rd_n && cd_n)       bus_i = cur_hi;
        else if (!rd_n && !cd_n) bus_i = cur_lo;
        else                     bus_i = 8'hC3;
    end

    always @(negedge clk) begin
        if (!rst_n) modecnt = 0;
        else begin
            if (!wr_n && rd_n && cd_n) modecnt++;
            if (bus_oe && !(!wr_n && rd_n && cd_n)) busviol++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [2:0] pat();
        return {wr_n, rd_n, cd_n};
    endfunction

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    endtask

    // Starts at a falling edge in the idle state.
    task automatic run_conv(input logic [30:0] v, input bit poke, input bit pre, input string sreq);
        logic [13:0] exp;
        cur_hi = v[30:23];
        cur_lo = v[22:15];
        ovd_n  = v[14];
        exp    = v[13:0];
        if (pre) @(negedge clk);
        else begin
            @(negedge clk) start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        chk(pat() == P_CONV, sreq, "conversion strobe", pat(), P_CONV);
        for (int i = 0; i < WAIT; i++) begin
            @(negedge clk);
            if (poke) start = 1'b1;
            chk(pat() == P_IDLE, "R4", "wait cycle strobes", pat(), P_IDLE);
        end
        @(negedge clk) start = 1'b0;
        chk(pat() == P_RDHI, "R5", "first read strobe", pat(), P_RDHI);
        @(negedge clk) if (poke) start = 1'b1;
        chk(pat() == P_IDLE, "R6", "gap between reads", pat(), P_IDLE);
        @(negedge clk) start = 1'b0;
        chk(pat() == P_RDLO, "R6", "second read strobe", pat(), P_RDLO);
        chk(done == 1'b0, "R7", "done before load", done, 0);
        @(negedge clk);
        chk(done == 1'b1, "R7", "done pulse", done, 1);
        chk(result == exp, "R7", "result word", result, exp);
        @(negedge clk);
        chk(done == 1'b0, "R7", "done one cycle", done, 0);
        chk(result == exp, "R7", "result holds", result, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        report();
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; ovd_n = 1'b1;
        cur_hi = 8'h00; cur_lo = 8'h00;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(pat() == P_IDLE, "R1", "strobes in reset", pat(), P_IDLE);
        chk(bus_oe == 1'b0, "R1", "bus enable in reset", bus_oe, 0);
        chk(done == 1'b0, "R1", "done in reset", done, 0);
        chk(result == 14'h0, "R1", "result in reset", result, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 programming cycle
        chk(pat() == P_MODE, "R2", "mode strobe", pat(), P_MODE);
        chk(bus_oe == 1'b1, "R2", "bus enable", bus_oe, 1);
        chk(bus_o[2:0] == 3'b000, "R2", "mode code", bus_o, 0);
        @(negedge clk);
        chk(pat() == P_IDLE && !bus_oe, "R2", "after mode", pat(), P_IDLE);
        @(negedge clk);
        chk(pat() == P_IDLE, "R2", "idle before start", pat(), P_IDLE);

        for (int k = 0; k < NV; k++) run_conv(VEC[k], 1'b0, 1'b0, "R3");

        // R8: requests during a busy sequence are dropped
        run_conv({8'h07, 8'hE4, 1'b1, 14'h07E4}, 1'b1, 1'b0, "R3");
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(pat() == P_IDLE, "R8", "no restart after busy start", pat(), P_IDLE);
        end

        // R9: start held across reset release
        @(negedge clk) rst_n = 1'b0; start = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pat() == P_MODE, "R2", "mode after second reset", pat(), P_MODE);
        start = 1'b0;
        @(negedge clk);
        chk(pat() == P_IDLE, "R9", "gap after mode", pat(), P_IDLE);
        @(negedge clk);
        chk(pat() == P_IDLE, "R9", "idle before held start", pat(), P_IDLE);
        run_conv({8'h3B, 8'h96, 1'b0, 14'h2B96}, 1'b0, 1'b1, "R9");

        chk(modecnt == 1, "R2", "mode cycles since reset", modecnt, 1);
        chk(busviol == 0, "R10", "bus driven outside mode", busviol, 0);
        report();
        $finish;
    end

endmodule